// File: doc/BRIEF.md
# Banked Interrupt Controller Register File

This block gathers 72 level-sensitive interrupt lines into three groups: two 32-line wide groups and one 8-line basic group. Each line has its own enable bit. Software changes the enables only through separate write-one-to-set and write-one-to-clear words, so no read-modify-write is ever needed. Each group exposes its enabled-and-active lines as a pending word. A summary word carries the basic group's pending lines together with one flag per wide group, so a handler can usually find the active group with a single read.

The controller drives one registered interrupt request towards the processor. That request stays high for as long as an enabled line stays high, because the block has no acknowledge path. For handler convenience, a combinational output gives the number of the lowest pending line, searching the basic group first. A plain 32-bit word is also kept for the fast-interrupt routing setting. The bus side is a simple word-indexed port: a write takes effect at the clock edge, and read data is registered.

Top module: `irq_bank_ctrl`

## Requirements
- R1: Synchronous active-high reset clears every enable bit, the fast-interrupt word, `rd_data` and `irq`.
- R2: A write to word 4, 5 or 6 sets the enable bit of every position written as 1, in wide group A (lines 0–31), wide group B (lines 32–63) or the basic group (lines 64–71) respectively. Positions written as 0 keep their enable. Line n sits at bit n mod 32 of its group.
- R3: A write to word 7, 8 or 9 clears the enable bit of every position written as 1, in group A, group B or the basic group respectively. Positions written as 0 keep their enable.
- R4: Reading word 1 returns the group A line levels ANDed with the group A enables. Reading word 2 does the same for group B.
- R5: Reading word 0 returns the basic pending lines on bits 7:0. Bit 8 is high when any group A line is pending and bit 9 is high when any group B line is pending. Bits 31:10 read 0.
- R6: Reading a set-enable or clear-enable word returns the current enable mask of that group, with the upper 24 bits zero for the basic group.
- R7: Word 3 is a 32-bit read/write holding register.
- R8: `irq` is high one cycle after any enabled line is high, and low one cycle after none is.
- R9: `low_valid` is high exactly when some line is pending. `low_num` gives the lowest pending basic line (64–71) if there is one, otherwise the lowest pending group A line, otherwise the lowest pending group B line. The search is combinational, from the current levels.
- R10: Writes to words 0, 1 and 2 change no state. Word indices 10–15 read 0.
- R11: `rd_data` presents the word selected by `addr` one clock edge after `addr` is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_lvl | input | 72 | Interrupt line levels, line n on bit n |
| wr_en | input | 1 | Write strobe for the word at `addr` |
| addr | input | 4 | Word index |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| irq | output | 1 | Registered interrupt request |
| low_valid | output | 1 | Some line is pending |
| low_num | output | 7 | Number of the lowest pending line |

## Verification
A walking single line across all 72 positions, with every enable set, checks the group decode, the bit-in-group position, the summary flags and the search result for each line in isolation. Pseudo-random level vectors combined with pseudo-random set and clear writes check that the masking and the set/clear semantics keep the untouched bits. Hand-picked collisions between the basic group and group A, and between the two wide groups, check the search order. Levels held high under an all-zero mask check that unmasked activity never leaks into the pending words, `irq` or the search.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;
  typedef enum logic [3:0] {
    REG_SUMMARY   = 4'd0,
    REG_PEND_A    = 4'd1,
    REG_PEND_B    = 4'd2,
    REG_FIQ       = 4'd3,
    REG_EN_A      = 4'd4,
    REG_EN_B      = 4'd5,
    REG_EN_BASIC  = 4'd6,
    REG_DIS_A     = 4'd7,
    REG_DIS_B     = 4'd8,
    REG_DIS_BASIC = 4'd9
  } reg_idx_e;
endpackage

// File: rtl/irq_low_find.sv
module irq_low_find #(
  parameter int W  = 32,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = |req;
    idx   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [W-1:0] bits,
  output logic [W-1:0] mask
);
  always_ff @(posedge clk) begin
    if (rst)         mask <= '0;
    else if (set_we) mask <= mask | bits;
    else if (clr_we) mask <= mask & ~bits;
  end
endmodule

// File: rtl/irq_bank_ctrl.sv
module irq_bank_ctrl
  import irq_bank_pkg::*;
#(
  parameter  int BANK_W  = 32,
  parameter  int BASIC_W = 8,
  parameter  int ADDR_W  = 4,
  localparam int NSRC    = 2 * BANK_W + BASIC_W,
  localparam int NUM_W   = $clog2(NSRC)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   src_lvl,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BANK_W-1:0] wr_data,
  output logic [BANK_W-1:0] rd_data,
  output logic              irq,
  output logic              low_valid,
  output logic [NUM_W-1:0]  low_num
);
  localparam int WIW = $clog2(BANK_W);
  localparam int BIW = $clog2(BASIC_W);

  logic [BANK_W-1:0]  en_w   [2];
  logic [BANK_W-1:0]  pend_w [2];
  logic [1:0]         any_w;
  logic [1:0]         found_w;
  logic [WIW-1:0]     idx_w  [2];
  logic [BASIC_W-1:0] en_basic;
  logic [BASIC_W-1:0] pend_basic;
  logic               found_b;
  logic [BIW-1:0]     idx_b;
  logic [BANK_W-1:0]  fiq_word;
  logic [BANK_W-1:0]  summary;
  logic [BANK_W-1:0]  rd_next;

  // Two wide groups share one structure
  for (genvar g = 0; g < 2; g++) begin : g_wide
    localparam logic [ADDR_W-1:0] SET_IDX = ADDR_W'(int'(REG_EN_A) + g);
    localparam logic [ADDR_W-1:0] CLR_IDX = ADDR_W'(int'(REG_DIS_A) + g);

    irq_mask_reg #(.W(BANK_W)) u_mask (
      .clk    (clk),
      .rst    (rst),
      .set_we (wr_en && (addr == SET_IDX)),
      .clr_we (wr_en && (addr == CLR_IDX)),
      .bits   (wr_data),
      .mask   (en_w[g])
    );

    assign pend_w[g] = src_lvl[g*BANK_W +: BANK_W] & en_w[g];
    assign any_w[g]  = |pend_w[g];

    irq_low_find #(.W(BANK_W)) u_find (
      .req   (pend_w[g]),
      .found (found_w[g]),
      .idx   (idx_w[g])
    );
  end

  irq_mask_reg #(.W(BASIC_W)) u_mask_basic (
    .clk    (clk),
    .rst    (rst),
    .set_we (wr_en && (addr == ADDR_W'(REG_EN_BASIC))),
    .clr_we (wr_en && (addr == ADDR_W'(REG_DIS_BASIC))),
    .bits   (wr_data[BASIC_W-1:0]),
    .mask   (en_basic)
  );

  assign pend_basic = src_lvl[NSRC-1 -: BASIC_W] & en_basic;

  irq_low_find #(.W(BASIC_W)) u_find_basic (
    .req   (pend_basic),
    .found (found_b),
    .idx   (idx_b)
  );

  // Lowest pending line: basic first, then group A, then group B
  always_comb begin
    low_valid = found_b | found_w[0] | found_w[1];
    if (found_b)
      low_num = NUM_W'(2 * BANK_W) + NUM_W'(idx_b);
    else if (found_w[0])
      low_num = NUM_W'(idx_w[0]);
    else if (found_w[1])
      low_num = NUM_W'(BANK_W) + NUM_W'(idx_w[1]);
    else
      low_num = '0;
  end

  always_comb begin
    summary                = '0;
    summary[BASIC_W-1:0]   = pend_basic;
    summary[BASIC_W]       = any_w[0];
    summary[BASIC_W+1]     = any_w[1];
  end

  always_comb begin
    unique case (addr)
      ADDR_W'(REG_SUMMARY):   rd_next = summary;
      ADDR_W'(REG_PEND_A):    rd_next = pend_w[0];
      ADDR_W'(REG_PEND_B):    rd_next = pend_w[1];
      ADDR_W'(REG_FIQ):       rd_next = fiq_word;
      ADDR_W'(REG_EN_A),
      ADDR_W'(REG_DIS_A):     rd_next = en_w[0];
      ADDR_W'(REG_EN_B),
      ADDR_W'(REG_DIS_B):     rd_next = en_w[1];
      ADDR_W'(REG_EN_BASIC),
      ADDR_W'(REG_DIS_BASIC): rd_next = BANK_W'(en_basic);
      default:                rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fiq_word <= '0;
      rd_data  <= '0;
      irq      <= 1'b0;
    end else begin
      if (wr_en && (addr == ADDR_W'(REG_FIQ))) fiq_word <= wr_data;
      rd_data <= rd_next;
      irq     <= (|pend_basic) | (|any_w);
    end
  end
endmodule

// File: rtl/irq_bank_ctrl_chk.sv
module irq_bank_ctrl_chk
  import irq_bank_pkg::*;
#(
  parameter  int BANK_W  = 32,
  parameter  int BASIC_W = 8,
  parameter  int ADDR_W  = 4,
  localparam int NSRC    = 2 * BANK_W + BASIC_W,
  localparam int NUM_W   = $clog2(NSRC)
) (
  input logic              clk,
  input logic              rst,
  input logic [NSRC-1:0]   src_lvl,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [BANK_W-1:0] wr_data,
  input logic [BANK_W-1:0] rd_data,
  input logic              irq,
  input logic              low_valid,
  input logic [NUM_W-1:0]  low_num,
  input logic [BANK_W-1:0] en_a,
  input logic [BANK_W-1:0] en_b,
  input logic [BASIC_W-1:0] en_basic
);
  a_r2_set_only: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(REG_EN_A)) |=>
      (((en_a & $past(wr_data)) == $past(wr_data)) && ((en_a & $past(en_a)) == $past(en_a))));

  a_r3_clear_only: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(REG_DIS_A)) |=>
      (((en_a & $past(wr_data)) == '0) && ((en_a | $past(wr_data)) == ($past(en_a) | $past(wr_data)))));

  a_r10_pend_write_ignored: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr <= ADDR_W'(REG_PEND_B)) |=>
      (en_a == $past(en_a) && en_b == $past(en_b) && en_basic == $past(en_basic)));

  a_r8_irq_rises: assert property (@(posedge clk) disable iff (rst)
    low_valid |=> irq);

  a_r8_irq_falls: assert property (@(posedge clk) disable iff (rst)
    !low_valid |=> !irq);

  a_r5_summary_top_zero: assert property (@(posedge clk) disable iff (rst)
    (addr == ADDR_W'(REG_SUMMARY)) |=> (rd_data[BANK_W-1:BASIC_W+2] == '0));

  a_r9_num_in_range: assert property (@(posedge clk) disable iff (rst)
    low_valid |-> (int'(low_num) < NSRC));

  a_r9_num_line_high: assert property (@(posedge clk) disable iff (rst)
    low_valid |-> src_lvl[low_num]);
endmodule

bind irq_bank_ctrl irq_bank_ctrl_chk #(
  .BANK_W (BANK_W),
  .BASIC_W(BASIC_W),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .src_lvl  (src_lvl),
  .wr_en    (wr_en),
  .addr     (addr),
  .wr_data  (wr_data),
  .rd_data  (rd_data),
  .irq      (irq),
  .low_valid(low_valid),
  .low_num  (low_num),
  .en_a     (en_w[0]),
  .en_b     (en_w[1]),
  .en_basic (en_basic)
);

// File: tb/irq_bank_ctrl_test.sv
module irq_bank_ctrl_test;
  logic        clk = 1'b0;
  logic        rst;
  logic [71:0] src_lvl;
  logic        wr_en;
  logic [3:0]  addr;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic        irq;
  logic        low_valid;
  logic [6:0]  low_num;

  always #10 clk = ~clk;

  irq_bank_ctrl uut (
    .clk(clk), .rst(rst), .src_lvl(src_lvl), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .irq(irq),
    .low_valid(low_valid), .low_num(low_num)
  );

  int n_chk  = 0;
  int n_fail = 0;
  bit ended  = 1'b0;

  logic [31:0] m_en_a, m_en_b, m_fiq;
  logic [7:0]  m_en_c;
  logic [31:0] seed = 32'h1234_5678;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] next_rand();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  function automatic logic [31:0] model_reg(int a);
    logic [31:0] pa, pb;
    logic [7:0]  pc;
    pa = src_lvl[31:0] & m_en_a;
    pb = src_lvl[63:32] & m_en_b;
    pc = src_lvl[71:64] & m_en_c;
    case (a)
      0:    return {22'd0, |pb, |pa, pc};
      1:    return pa;
      2:    return pb;
      3:    return m_fiq;
      4, 7: return m_en_a;
      5, 8: return m_en_b;
      6, 9: return {24'd0, m_en_c};
      default: return 32'd0;
    endcase
  endfunction

  function automatic int model_low();
    logic [71:0] p;
    p = src_lvl & {m_en_c, m_en_b, m_en_a};
    for (int i = 64; i < 72; i++) if (p[i]) return i;
    for (int i = 0; i < 64; i++) if (p[i]) return i;
    return -1;
  endfunction

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    addr = 4'(a); wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    case (a)
      3: m_fiq  = d;
      4: m_en_a = m_en_a | d;
      5: m_en_b = m_en_b | d;
      6: m_en_c = m_en_c | d[7:0];
      7: m_en_a = m_en_a & ~d;
      8: m_en_b = m_en_b & ~d;
      9: m_en_c = m_en_c & ~d[7:0];
      default: ;
    endcase
  endtask

  task automatic rd(int a, string req);
    @(negedge clk);
    addr = 4'(a);
    @(negedge clk);
    check(req, rd_data, model_reg(a));
  endtask

  task automatic check_search(string req);
    int e;
    e = model_low();
    check(req, 32'(low_valid), 32'(e >= 0));
    if (e >= 0) check(req, 32'(low_num), 32'(e));
    check({req, " irq"}, 32'(irq), 32'(e >= 0));
  endtask

  task automatic check_all(string req);
    for (int a = 0; a < 10; a++) rd(a, req);
    check_search(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; wr_en = 1'b0; addr = '0; wr_data = '0; src_lvl = '1;
    m_en_a = '0; m_en_b = '0; m_en_c = '0; m_fiq = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: everything cleared; lines high but masked out
    check("R1 rd_data", rd_data, 32'd0);
    check("R1 irq", 32'(irq), 32'd0);
    check_all("R1 after reset");

    // R7: holding register
    wr(3, 32'hA5A5_5A5A);
    rd(3, "R7 fiq word");
    wr(3, 32'h0F0F_00FF);
    check_all("R7 others untouched");

    // R11: read data appears one edge after addr
    @(negedge clk); addr = 4'd3;
    @(negedge clk); addr = 4'd5;
    #2 check("R11 data not early", rd_data, m_fiq);
    @(negedge clk); check("R11 data after edge", rd_data, model_reg(5));

    // R2 / R6: set-only enables, read through both words of each group
    src_lvl = '0;
    wr(4, 32'h0000_00F0); wr(4, 32'h0000_0F00);
    check("R2 set A accumulates", m_en_a, 32'h0000_0FF0);
    rd(4, "R2 enable A"); rd(7, "R6 enable A via clear word");
    wr(5, 32'h8000_0001); rd(5, "R2 enable B"); rd(8, "R6 enable B via clear word");
    wr(6, 32'hFFFF_FF81); rd(6, "R6 enable basic upper zero"); rd(9, "R6 basic via clear word");

    // R3: clear-only
    wr(7, 32'h0000_0030); rd(4, "R3 clear A");
    wr(8, 32'h0000_0001); rd(5, "R3 clear B");
    wr(9, 32'h0000_0080); rd(9, "R3 clear basic");

    // R10: writes to pending words ignored; unmapped reads zero
    wr(0, 32'hFFFF_FFFF); wr(1, 32'hFFFF_FFFF); wr(2, 32'hFFFF_FFFF);
    check_all("R10 pending writes ignored");
    for (int a = 10; a < 16; a++) rd(a, "R10 unmapped reads zero");

    // Walking single line with all enables set: R4 R5 R8 R9
    wr(4, '1); wr(5, '1); wr(6, '1);
    for (int n = 0; n < 72; n++) begin
      @(negedge clk); src_lvl = 72'(1) << n;
      @(negedge clk);
      check_search("R8 R9 walking line");
      rd(0, "R5 summary walking"); rd(1, "R4 pend A walking"); rd(2, "R4 pend B walking");
      @(negedge clk); src_lvl = '0;
      @(negedge clk);
      check("R8 irq drops", 32'(irq), 32'd0);
    end

    // R9 search order
    @(negedge clk); src_lvl = '0; src_lvl[70] = 1'b1; src_lvl[3] = 1'b1;
    @(negedge clk); check("R9 basic before A", 32'(low_num), 32'd70);
    @(negedge clk); src_lvl = '0; src_lvl[40] = 1'b1; src_lvl[31] = 1'b1;
    @(negedge clk); check("R9 A before B", 32'(low_num), 32'd31);

    // Random levels and masks: R2 R3 R4 R5 R9
    for (int it = 0; it < 40; it++) begin
      @(negedge clk); src_lvl = {next_rand(), next_rand(), next_rand()}[71:0];
      wr(4 + (it % 3), next_rand());
      wr(7 + ((it + 1) % 3), next_rand());
      check_all("R4 R5 R9 random");
    end

    // Masked-off activity leaks nowhere: R4 R8 R9
    wr(7, '1); wr(8, '1); wr(9, '1);
    @(negedge clk); src_lvl = '1;
    @(negedge clk);
    check_all("R4 R8 R9 all masked");

    ended = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule